// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the order of column addresses for a single burst into one row of a synchronous DRAM-style memory. A one-cycle start strobe loads a starting column, a burst length code and an ordering choice (linear or XOR-interleaved). From the next cycle on, the block puts out one column address per clock until the burst is complete. Every address stays inside the naturally aligned group of columns whose size equals the burst length. The upper column bits name that group, and the low bits of the start column give the entry point inside it.

The row holds 256 columns. A page-length burst walks the entire row linearly and wraps from the top column to column 0. It never completes by itself and runs until the terminate input stops it. Requests the block cannot honour run linearly, and an error indication accompanies every beat of such a burst. A fresh start strobe always abandons any burst still in progress.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, with no start strobe, `valid_o`, `last_o` and `err_o` are 0.
- R2: In the cycle after a clock edge at which `start_i` is 1, `valid_o` is 1 and `col_o` equals the sampled `start_col_i`; each later beat appears on the immediately following cycle.
- R3: `len_i` codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `last_o` is 1 on the final beat only, and `valid_o` is 0 in the cycle after it unless a new start was sampled.
- R4: With `ilv_i`=0 and length L, beat n outputs the start column with its low log2(L) bits replaced by (those bits + n) mod L. The upper bits are unchanged.
- R5: With `ilv_i`=1 and length 2, 4 or 8, beat n outputs the start column with its low log2(L) bits XORed with n (start 1, length 4 gives 1, 0, 3, 2).
- R6: With length code 0, exactly one beat equal to the start column is produced, and `ilv_i` has no effect on it.
- R7: Length code 7 is a page burst. Beat n is (start + n) mod 256, `last_o` stays 0, and beats continue without end, wrapping from 255 to 0.
- R8: When `term_i` is 1 at an edge where `valid_o` is 1 and `start_i` is 0, `valid_o` is 0 in the next cycle. When the block is idle, `term_i` has no effect.
- R9: Length codes 4, 5 and 6 run as a single-beat burst. Code 7 with `ilv_i`=1 runs as a linear page burst. In both cases `err_o` is 1 on every beat of that burst. `err_o` is 0 on the beats of all supported requests and whenever `valid_o` is 0.
- R10: A start strobe during a burst abandons the old burst. The next cycle shows beat 0 of the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load a new burst request |
| start_col_i | input | 8 | Starting column |
| len_i | input | 3 | Burst length code: 0=1, 1=2, 2=4, 3=8, 7=page, 4..6 unsupported |
| ilv_i | input | 1 | 0 = linear order, 1 = interleaved order |
| term_i | input | 1 | Stop the running burst |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | The current burst came from an unsupported request |

## Verification
The hardest condition to reach is the row-end wrap of a page burst. Beats only continue past column 255 after a long unbroken run, and `last_o` must stay low through the whole run. The stimulus holds one page burst from column 250 for 300 beats, and runs another in the unsupported interleaved form for 260 beats. Every beat is compared with (start + n) mod 256. All 256 start columns are also swept against every length code and both orderings. This covers each in-block entry point, each group base, and the reserved codes.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam logic [2:0] LEN_ONE   = 3'd0;
    localparam logic [2:0] LEN_TWO   = 3'd1;
    localparam logic [2:0] LEN_FOUR  = 3'd2;
    localparam logic [2:0] LEN_EIGHT = 3'd3;
    localparam logic [2:0] LEN_PAGE  = 3'd7;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o,
    output logic             ilv_o,
    output logic             err_o
);

    always_comb begin
        mask_o = '0;
        page_o = 1'b0;
        ilv_o  = 1'b0;
        err_o  = 1'b0;
        unique case (len_i)
            LEN_ONE: begin
                mask_o = '0;
            end
            LEN_TWO: begin
                mask_o = COL_W'(1);
                ilv_o  = ilv_i;
            end
            LEN_FOUR: begin
                mask_o = COL_W'(3);
                ilv_o  = ilv_i;
            end
            LEN_EIGHT: begin
                mask_o = COL_W'(7);
                ilv_o  = ilv_i;
            end
            LEN_PAGE: begin
                mask_o = '1;
                page_o = 1'b1;
                err_o  = ilv_i;
            end
            default: begin
                mask_o = '0;
                err_o  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] off_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] lin_w;
    logic [COL_W-1:0] xor_w;

    always_comb begin
        lin_w = off_i + beat_i;
        xor_w = off_i ^ beat_i;
        col_o = base_i | ((ilv_i ? xor_w : lin_w) & mask_i);
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_i,
    input  logic             ilv_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);

    typedef struct packed {
        logic             busy;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] off;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
        logic             ilv;
        logic             page;
        logic             err;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             dec_ilv;
    logic             dec_err;
    logic             final_beat;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .len_i  (len_i),
        .ilv_i  (ilv_i),
        .mask_o (dec_mask),
        .page_o (dec_page),
        .ilv_o  (dec_ilv),
        .err_o  (dec_err)
    );

    burst_col_gen #(.COL_W(COL_W)) u_gen (
        .base_i (st_q.base),
        .off_i  (st_q.off),
        .beat_i (st_q.beat),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .col_o  (col_o)
    );

    assign final_beat = st_q.busy && !st_q.page && (st_q.beat == st_q.mask);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.base = start_col_i & ~dec_mask;
            st_d.off  = start_col_i & dec_mask;
            st_d.beat = '0;
            st_d.mask = dec_mask;
            st_d.ilv  = dec_ilv;
            st_d.page = dec_page;
            st_d.err  = dec_err;
        end else if (st_q.busy) begin
            if (term_i || final_beat) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.busy;
    assign last_o  = final_beat;
    assign err_o   = st_q.busy && st_q.err;

    // R1 / R3: a final-beat marker only ever accompanies a presented beat
    a_r3_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R3: the burst ends right after its final beat
    a_r3_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    // R2 / R10: a start shows the requested column on the next cycle
    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    // R8: terminate stops a running burst
    a_r8_terminate: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && term_i && !start_i) |=> !valid_o);

    // R7: page bursts advance by one column per cycle and never mark last
    a_r7_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && st_q.page && !term_i && !start_i) |=>
            (valid_o && !last_o && col_o == $past(col_o) + 1'b1));

    // R9: the error indication is confined to presented beats
    a_r9_err_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> valid_o);

    // R1: idle without a start stays idle
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> !valid_o);

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] len_i = '0;
    logic       ilv_i = 1'b0;
    logic       term_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o;
    logic       last_o;
    logic       err_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq #(.COL_W(8)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len_i       (len_i),
        .ilv_i       (ilv_i),
        .term_i      (term_i),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o),
        .err_o       (err_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_col(input int s, input int m, input bit x, input int n);
        int lo;
        lo = x ? ((s & m) ^ n) : (((s & m) + n) & m);
        return (s & ~m & 255) | lo;
    endfunction

    // Runs one burst and checks each beat; page bursts stop after pb beats.
    task automatic burst(input int s, input int code, input bit typ, input int pb);
        int len; bit page; bit x; bit e; int nb; string tag;
        page = (code == 7);
        e    = (code >= 4 && code <= 6) || (page && typ);
        case (code)
            0: len = 1; 1: len = 2; 2: len = 4; 3: len = 8; 7: len = 256;
            default: len = 1;
        endcase
        x  = typ && code >= 1 && code <= 3;
        nb = page ? pb : len;
        if (e)           tag = "R9";
        else if (page)   tag = "R7";
        else if (code == 0) tag = typ ? "R6" : "R3";
        else if (x)      tag = "R5";
        else             tag = "R4";
        @(negedge clk);
        start_i = 1'b1; start_col_i = 8'(s); len_i = 3'(code); ilv_i = typ;
        for (int n = 0; n < nb; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            chk(valid_o === 1'b1, (n == 0) ? "R2" : tag, "valid", int'(valid_o), 1);
            chk(col_o === 8'(exp_col(s, len - 1, x, n)), tag, "col",
                int'(col_o), exp_col(s, len - 1, x, n));
            chk(last_o === (!page && n == len - 1), "R3", "last",
                int'(last_o), int'(!page && n == len - 1));
            chk(err_o === e, "R9", "err", int'(err_o), int'(e));
            if (page && n == nb - 1) term_i = 1'b1;
        end
        @(negedge clk);
        chk(valid_o === 1'b0, page ? "R8" : "R3", "valid after end", int'(valid_o), 0);
        term_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(valid_o === 1'b0, "R1", "valid in reset", int'(valid_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(valid_o === 1'b0 && last_o === 1'b0 && err_o === 1'b0, "R1",
            "outputs after reset", int'({valid_o, last_o, err_o}), 0);

        // R8: terminate while idle has no effect
        term_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(valid_o === 1'b0, "R8", "idle terminate", int'(valid_o), 0);
        term_i = 1'b0;

        // Sweep all starts, codes and orderings (page bursts cut to 3 beats)
        for (int s = 0; s < 256; s++)
            for (int c = 0; c < 8; c++)
                for (int t = 0; t < 2; t++)
                    burst(s, c, t[0], 3);

        // R7: long page bursts across the row end
        burst(250, 7, 1'b0, 300);
        burst(3, 7, 1'b1, 260);

        // R8: terminate in the middle of an 8-beat burst
        @(negedge clk);
        start_i = 1'b1; start_col_i = 8'd0; len_i = 3'd3; ilv_i = 1'b0;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        chk(col_o === 8'd1, "R8", "col before term", int'(col_o), 1);
        term_i = 1'b1;
        @(negedge clk); term_i = 1'b0;
        chk(valid_o === 1'b0, "R8", "valid after term", int'(valid_o), 0);

        // R10: restart in mid-burst with interleaved length 4 from 5
        @(negedge clk);
        start_i = 1'b1; start_col_i = 8'd16; len_i = 3'd3; ilv_i = 1'b0;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        chk(col_o === 8'd17, "R10", "old burst beat1", int'(col_o), 17);
        start_i = 1'b1; start_col_i = 8'd5; len_i = 3'd2; ilv_i = 1'b1;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            chk(col_o === 8'(4 | (1 ^ n)), "R10", "restart col", int'(col_o), 4 | (1 ^ n));
            chk(last_o === (n == 3), "R10", "restart last", int'(last_o), int'(n == 3));
        end
        @(negedge clk);
        chk(valid_o === 1'b0, "R10", "restart end", int'(valid_o), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule